// File: doc/BRIEF.md
# Indexed single-pin GPIO register writer

This block holds the per-bank configuration and status registers of a GPIO controller and updates them one pin at a time. Software issues one 32-bit command word with a write strobe. The word names a pin by number and a register class, and carries the new bit values. Only the bits that belong to the addressed pin change, apart from the rules that re-apply the bank's pin-capability masks. The pins are split into banks of 32. Each register is exposed to the rest of the controller as a flat vector with one bit per pin, so bit `n` of every output belongs to pin `n`.

Interrupt status bits are set by a qualified event input and are cleared by writing one through the interrupt class. A running count of the set status bits is kept alongside them. A command word with the reserved command bit set, or with an unknown class, raises a one-cycle error flag. An unknown class leaves every register untouched. A word with the command bit set is still applied.

Command word layout: bits 7:0 pin number, bit 12 reserved command bit, bits 19:16 register class, bits 24:20 value bits v0..v4 (v0 is bit 20). The bank is the pin number divided by 32. The bit position is the remainder. The 8-pin group is the bit position divided by 8. The default capabilities for every bank are as follows:
- bits 0–7 and 24–27 are bidirectional.
- bits 8–15 are output-only.
- bits 16–23 are input-only.
- bits 28–31 are absent.
- The command-source mask keeps bits 0, 8, 16 and 24.

Top module: `gpio_index_writer`

## Requirements
- R1: While reset is low at a clock edge, every register output, `irq_pending` and `cmd_err` become 0.
- R2: When `wr_en` is high at a clock edge, the register class is taken from bits 19:16: 0 data, 1 direction, 2 interrupt, 3 debounce, 4 reset tolerance, 5 command source, 6 input mask. The write targets pin number bits 7:0. That pin's bit is bank×32 + position in every output. Except where a masking rule says otherwise, no other pin's bit changes.
- R3: A data write sets the pin's `pin_data` bit to v0. The bank's data word is then ANDed with its output-capable mask.
- R4: A direction write places v0 in the pin's bit. The whole bank word is then stored as (word OR NOT input-capable) AND output-capable. As a result, output-only pins read 1, input-only and absent pins read 0, and bidirectional pins keep the written value.
- R5: An interrupt write stores v0 in `irq_en`, v1 in `irq_sens0`, v2 in `irq_sens1` and v3 in `irq_sens2` for the pin. If v4 is 1, the pin's `irq_stat` bit is cleared (write-one-to-clear). If v4 is 0, the status bit is left unchanged.
- R6: An `irq_raise` bit sets that pin's status bit at the clock edge, and this wins over a clear in the same cycle. `irq_pending` always equals the number of set status bits. It goes up by the bits newly set and down by the bits cleared, and never below zero.
- R7: A debounce write stores v0 in `dbnc_sel1` and v1 in `dbnc_sel2`. A reset-tolerance write stores v0 in `rst_tol`.
- R8: A command-source write stores v0 in `csrc0` and v1 in `csrc1`, at bit 8×group of the bank rather than at the pin's own bit. Each bank word is then ANDed with the command-source mask.
- R9: An input-mask write stores v0 at the pin's bit, ANDed with the bank's input-capable mask.
- R10: A strobed word with class 7 to 15 changes no register. It also makes `cmd_err` 1 for exactly the following cycle.
- R11: A strobed word with bit 12 set makes `cmd_err` 1 for the following cycle. Its write is still carried out.
- R12: Writes become visible on the outputs after the clock edge at which `wr_en` is high. With `wr_en` low, `wr_data` has no effect and `cmd_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word |
| irq_raise | input | 256 | Per-pin qualified interrupt events that set status |
| pin_data | output | 256 | Data register readback |
| pin_dir | output | 256 | Direction register (1 = output) |
| irq_en | output | 256 | Interrupt enable |
| irq_sens0 | output | 256 | Interrupt sensitivity bit 0 |
| irq_sens1 | output | 256 | Interrupt sensitivity bit 1 |
| irq_sens2 | output | 256 | Interrupt sensitivity bit 2 |
| irq_stat | output | 256 | Interrupt status |
| dbnc_sel1 | output | 256 | Debounce select 1 |
| dbnc_sel2 | output | 256 | Debounce select 2 |
| rst_tol | output | 256 | Reset tolerance |
| csrc0 | output | 256 | Command source bit 0 (group-level) |
| csrc1 | output | 256 | Command source bit 1 (group-level) |
| in_mask | output | 256 | Input mask |
| irq_pending | output | 9 | Count of set status bits |
| cmd_err | output | 1 | One-cycle error flag for a bad command word |

## Verification
Directed writes address pins in each capability region: bidirectional, output-only, input-only and absent. This separates a correct mask from a missing or inverted one in the data, direction and input-mask paths. A write to a pin in a bank other than 0 shows whether the bank/position split is right. A strobe-low cycle with a live command word shows whether the strobe gates the write. A long pseudo-random phase mixes the following: all sixteen class codes, the reserved command bit, clears of pins that are set and of pins that are not, and raises that land on the same pin as a clear. Every output is compared with a behavioural model on every cycle, so group placement of command-source bits and pending-count drift show up as soon as they occur.

// File: rtl/gpio_idx_pkg.sv
// Package: command word layout and register class codes for the indexed
// GPIO writer. Assumes a 32-bit command word; field positions are fixed
// because software builds the word.
package gpio_idx_pkg;
    localparam int PIN_LSB = 0;
    localparam int PIN_W   = 8;
    localparam int CMD_BIT = 12;
    localparam int CLS_LSB = 16;
    localparam int CLS_W   = 4;
    localparam int VAL_LSB = 20;
    localparam int VAL_W   = 5;
    localparam int GRP_W   = 8;

    typedef enum logic [CLS_W-1:0] {
        CLS_DATA  = 4'd0,
        CLS_DIR   = 4'd1,
        CLS_INT   = 4'd2,
        CLS_DEB   = 4'd3,
        CLS_RTOL  = 4'd4,
        CLS_CSRC  = 4'd5,
        CLS_IMASK = 4'd6
    } reg_class_e;

    localparam logic [CLS_W-1:0] CLS_LAST = 4'd6;
endpackage

// File: rtl/gpio_cmd_decode.sv
// Module: splits a strobed command word into bank select, bit position,
// class and value bits, and flags bad words. Purely combinational;
// assumes NBANK*BANK_W covers the pins software will address.
module gpio_cmd_decode
    import gpio_idx_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = 32,
    localparam int BPW   = $clog2(BANK_W)
) (
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [NBANK-1:0]  bank_wr,
    output logic [BPW-1:0]    bit_pos,
    output reg_class_e        cls,
    output logic [VAL_W-1:0]  vals,
    output logic              bad
);
    logic [PIN_W-1:0] pin;
    logic [CLS_W-1:0] cls_raw;
    logic             cls_ok;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[31:25], wr_data[15:13], wr_data[11:8]};

    // Field extraction, class validity and per-bank write select.
    always_comb begin
        pin     = wr_data[PIN_LSB +: PIN_W];
        cls_raw = wr_data[CLS_LSB +: CLS_W];
        cls_ok  = (cls_raw <= CLS_LAST);
        cls     = reg_class_e'(cls_raw);
        vals    = wr_data[VAL_LSB +: VAL_W];
        bit_pos = BPW'(int'(pin) % BANK_W);
        bad     = wr_en && (wr_data[CMD_BIT] || !cls_ok);
        for (int b = 0; b < NBANK; b++)
            bank_wr[b] = wr_en && cls_ok && ((int'(pin) / BANK_W) == b);
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Module: registers of one bank. Applies a decoded single-pin write with
// capability and command-source masking, sets status from raise events,
// clears it on write-one, and reports how many status bits it set/cleared.
// Assumes at most one write per cycle; raise wins over clear on a pin.
module gpio_bank_regs
    import gpio_idx_pkg::*;
#(
    parameter int                BANK_W    = 32,
    parameter logic [BANK_W-1:0] IN_CAP    = 32'h0FFF_00FF,
    parameter logic [BANK_W-1:0] OUT_CAP   = 32'h0F00_FFFF,
    parameter logic [BANK_W-1:0] CSRC_MASK = 32'h0101_0101,
    localparam int BPW = $clog2(BANK_W),
    localparam int BCW = $clog2(BANK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_class_e        cls,
    input  logic [BPW-1:0]    bit_pos,
    input  logic [VAL_W-1:0]  vals,
    input  logic [BANK_W-1:0] raise,
    output logic [BANK_W-1:0] data_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] s0_q,
    output logic [BANK_W-1:0] s1_q,
    output logic [BANK_W-1:0] s2_q,
    output logic [BANK_W-1:0] stat_q,
    output logic [BANK_W-1:0] db1_q,
    output logic [BANK_W-1:0] db2_q,
    output logic [BANK_W-1:0] rtol_q,
    output logic [BANK_W-1:0] c0_q,
    output logic [BANK_W-1:0] c1_q,
    output logic [BANK_W-1:0] im_q,
    output logic [BCW-1:0]    clr_cnt,
    output logic [BCW-1:0]    set_cnt
);
    logic [BANK_W-1:0] sel, grp_sel, clr, kept;
    logic [BANK_W-1:0] n_data, n_dir, n_en, n_s0, n_s1, n_s2, n_stat;
    logic [BANK_W-1:0] n_db1, n_db2, n_rtol, n_c0, n_c1, n_im;

    function automatic logic [BANK_W-1:0] put(input logic [BANK_W-1:0] old,
                                              input logic v,
                                              input logic [BANK_W-1:0] at);
        return (old & ~at) | (v ? at : '0);
    endfunction

    // Next-state for every register of the bank from one decoded write.
    always_comb begin
        sel     = BANK_W'(1) << bit_pos;
        grp_sel = BANK_W'(1) << ((int'(bit_pos) / GRP_W) * GRP_W);
        n_data = data_q; n_dir = dir_q; n_en = en_q; n_s0 = s0_q;
        n_s1 = s1_q; n_s2 = s2_q; n_db1 = db1_q; n_db2 = db2_q;
        n_rtol = rtol_q; n_c0 = c0_q; n_c1 = c1_q; n_im = im_q;
        clr = '0;
        if (wr) begin
            case (cls)
                CLS_DATA:  n_data = put(data_q, vals[0], sel) & OUT_CAP;
                CLS_DIR:   n_dir  = (put(dir_q, vals[0], sel) | ~IN_CAP) & OUT_CAP;
                CLS_INT: begin
                    n_en = put(en_q, vals[0], sel);
                    n_s0 = put(s0_q, vals[1], sel);
                    n_s1 = put(s1_q, vals[2], sel);
                    n_s2 = put(s2_q, vals[3], sel);
                    clr  = sel & {BANK_W{vals[4]}};
                end
                CLS_DEB: begin
                    n_db1 = put(db1_q, vals[0], sel);
                    n_db2 = put(db2_q, vals[1], sel);
                end
                CLS_RTOL:  n_rtol = put(rtol_q, vals[0], sel);
                CLS_CSRC: begin
                    n_c0 = put(c0_q, vals[0], grp_sel) & CSRC_MASK;
                    n_c1 = put(c1_q, vals[1], grp_sel) & CSRC_MASK;
                end
                CLS_IMASK: n_im = put(im_q, vals[0], sel) & IN_CAP;
                default: ;
            endcase
        end
        kept    = stat_q & ~clr;
        n_stat  = kept | raise;
        clr_cnt = BCW'($countones(stat_q & clr));
        set_cnt = BCW'($countones(raise & ~kept));
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0; dir_q <= '0; en_q <= '0; s0_q <= '0; s1_q <= '0;
            s2_q <= '0; stat_q <= '0; db1_q <= '0; db2_q <= '0;
            rtol_q <= '0; c0_q <= '0; c1_q <= '0; im_q <= '0;
        end else begin
            data_q <= n_data; dir_q <= n_dir; en_q <= n_en; s0_q <= n_s0;
            s1_q <= n_s1; s2_q <= n_s2; stat_q <= n_stat; db1_q <= n_db1;
            db2_q <= n_db2; rtol_q <= n_rtol; c0_q <= n_c0; c1_q <= n_c1;
            im_q <= n_im;
        end
    end

    // R3: data bits only ever exist on output-capable pins.
    p_data_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q & ~OUT_CAP) == '0);
    // R4: after a direction write output-only pins read 1.
    p_dir_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cls == CLS_DIR) |=> ((dir_q & ~IN_CAP & OUT_CAP) == (~IN_CAP & OUT_CAP)));
    // R4: no direction bit on a pin without output capability.
    p_dir_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~OUT_CAP) == '0);
    // R5: write-one clears the status bit when no raise hits the same pin.
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cls == CLS_INT && vals[4] && (raise & sel) == '0)
        |=> (stat_q & (BANK_W'(1) << $past(bit_pos))) == '0);
    // R8: command-source words stay inside the mask.
    p_csrc_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0_q | c1_q) & ~CSRC_MASK) == '0);
    // R9: input mask only on input-capable pins.
    p_imask_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (im_q & ~IN_CAP) == '0);
endmodule

// File: rtl/gpio_pending_ctr.sv
// Module: running count of set interrupt status bits, updated from the
// per-bank set and clear counts. Assumes each bank's clear count never
// exceeds the bits it actually had set.
module gpio_pending_ctr #(
    parameter int NBANK  = 8,
    parameter int BANK_W = 32,
    localparam int BCW   = $clog2(BANK_W + 1),
    localparam int PCW   = $clog2(NBANK * BANK_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBANK*BCW-1:0] clr_cnt,
    input  logic [NBANK*BCW-1:0] set_cnt,
    output logic [PCW-1:0]       pending
);
    logic [PCW-1:0] clr_tot, set_tot;

    // Sum the per-bank counts.
    always_comb begin
        clr_tot = '0;
        set_tot = '0;
        for (int b = 0; b < NBANK; b++) begin
            clr_tot = clr_tot + PCW'(clr_cnt[b*BCW +: BCW]);
            set_tot = set_tot + PCW'(set_cnt[b*BCW +: BCW]);
        end
    end

    // Apply the net change to the pending count.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= pending - clr_tot + set_tot;
    end

    // R6: clears never take the count below zero.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tot <= pending);
    // R6: count stays within the number of pins.
    p_pending_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= NBANK * BANK_W);
endmodule

// File: rtl/gpio_index_writer.sv
// Module: top of the indexed single-pin GPIO register writer. Decodes one
// command word per strobe, routes it to the addressed bank, keeps the
// pending-interrupt count and pulses an error flag for bad words.
// Assumes every bank shares the same capability and command-source masks.
module gpio_index_writer
    import gpio_idx_pkg::*;
#(
    parameter int                NBANK       = 8,
    parameter int                BANK_W      = 32,
    parameter logic [BANK_W-1:0] IN_CAP_BANK = 32'h0FFF_00FF,
    parameter logic [BANK_W-1:0] OUT_CAP_BANK = 32'h0F00_FFFF,
    parameter logic [BANK_W-1:0] CSRC_MASK   = 32'h0101_0101,
    localparam int NPINS = NBANK * BANK_W,
    localparam int BPW   = $clog2(BANK_W),
    localparam int BCW   = $clog2(BANK_W + 1),
    localparam int PCW   = $clog2(NPINS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [NPINS-1:0] irq_raise,
    output logic [NPINS-1:0] pin_data,
    output logic [NPINS-1:0] pin_dir,
    output logic [NPINS-1:0] irq_en,
    output logic [NPINS-1:0] irq_sens0,
    output logic [NPINS-1:0] irq_sens1,
    output logic [NPINS-1:0] irq_sens2,
    output logic [NPINS-1:0] irq_stat,
    output logic [NPINS-1:0] dbnc_sel1,
    output logic [NPINS-1:0] dbnc_sel2,
    output logic [NPINS-1:0] rst_tol,
    output logic [NPINS-1:0] csrc0,
    output logic [NPINS-1:0] csrc1,
    output logic [NPINS-1:0] in_mask,
    output logic [PCW-1:0]   irq_pending,
    output logic             cmd_err
);
    logic [NBANK-1:0]     bank_wr;
    logic [BPW-1:0]       bit_pos;
    reg_class_e           cls;
    logic [VAL_W-1:0]     vals;
    logic                 bad;
    logic [NBANK*BCW-1:0] clr_cnt, set_cnt;

    gpio_cmd_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .wr_en(wr_en), .wr_data(wr_data), .bank_wr(bank_wr),
        .bit_pos(bit_pos), .cls(cls), .vals(vals), .bad(bad)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_bank_regs #(
            .BANK_W(BANK_W), .IN_CAP(IN_CAP_BANK), .OUT_CAP(OUT_CAP_BANK),
            .CSRC_MASK(CSRC_MASK)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .wr(bank_wr[b]), .cls(cls),
            .bit_pos(bit_pos), .vals(vals),
            .raise(irq_raise[b*BANK_W +: BANK_W]),
            .data_q(pin_data[b*BANK_W +: BANK_W]),
            .dir_q(pin_dir[b*BANK_W +: BANK_W]),
            .en_q(irq_en[b*BANK_W +: BANK_W]),
            .s0_q(irq_sens0[b*BANK_W +: BANK_W]),
            .s1_q(irq_sens1[b*BANK_W +: BANK_W]),
            .s2_q(irq_sens2[b*BANK_W +: BANK_W]),
            .stat_q(irq_stat[b*BANK_W +: BANK_W]),
            .db1_q(dbnc_sel1[b*BANK_W +: BANK_W]),
            .db2_q(dbnc_sel2[b*BANK_W +: BANK_W]),
            .rtol_q(rst_tol[b*BANK_W +: BANK_W]),
            .c0_q(csrc0[b*BANK_W +: BANK_W]),
            .c1_q(csrc1[b*BANK_W +: BANK_W]),
            .im_q(in_mask[b*BANK_W +: BANK_W]),
            .clr_cnt(clr_cnt[b*BCW +: BCW]),
            .set_cnt(set_cnt[b*BCW +: BCW])
        );
    end

    gpio_pending_ctr #(.NBANK(NBANK), .BANK_W(BANK_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .set_cnt(set_cnt),
        .pending(irq_pending)
    );

    // Register the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= bad;
    end

    // R10: unknown class pulses the flag next cycle.
    p_bad_cls_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CLS_LSB +: CLS_W] > CLS_LAST) |=> cmd_err);
    // R10: unknown class leaves configuration untouched.
    p_bad_cls_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CLS_LSB +: CLS_W] > CLS_LAST)
        |=> ($stable(pin_data) && $stable(pin_dir) && $stable(irq_en) &&
             $stable(csrc0) && $stable(in_mask)));
    // R11: reserved command bit pulses the flag next cycle.
    p_cmd_bit_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_BIT]) |=> cmd_err);
    // R12: no strobe, no error and no configuration change.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!cmd_err && $stable(pin_data) && $stable(pin_dir)));
endmodule

// File: tb/gpio_index_writer_bench.sv
module gpio_index_writer_bench;
    localparam int NBANK = 8;
    localparam int BW    = 32;
    localparam int NP    = NBANK * BW;
    localparam logic [31:0] INC = 32'h0FFF_00FF;
    localparam logic [31:0] OUC = 32'h0F00_FFFF;
    localparam logic [31:0] CSM = 32'h0101_0101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [NP-1:0] irq_raise = '0;
    logic [NP-1:0] pin_data, pin_dir, irq_en, irq_sens0, irq_sens1, irq_sens2;
    logic [NP-1:0] irq_stat, dbnc_sel1, dbnc_sel2, rst_tol, csrc0, csrc1, in_mask;
    logic [8:0]    irq_pending;
    logic          cmd_err;

    always #10 clk = ~clk;

    gpio_index_writer #(.NBANK(NBANK), .BANK_W(BW), .IN_CAP_BANK(INC),
                        .OUT_CAP_BANK(OUC), .CSRC_MASK(CSM)) u_gpio_index_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_raise(irq_raise), .pin_data(pin_data), .pin_dir(pin_dir),
        .irq_en(irq_en), .irq_sens0(irq_sens0), .irq_sens1(irq_sens1),
        .irq_sens2(irq_sens2), .irq_stat(irq_stat), .dbnc_sel1(dbnc_sel1),
        .dbnc_sel2(dbnc_sel2), .rst_tol(rst_tol), .csrc0(csrc0), .csrc1(csrc1),
        .in_mask(in_mask), .irq_pending(irq_pending), .cmd_err(cmd_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model state.
    logic [NP-1:0] m_d, m_dir, m_en, m_s0, m_s1, m_s2, m_st;
    logic [NP-1:0] m_db1, m_db2, m_rt, m_c0, m_c1, m_im;
    int            m_pend;
    logic          m_err;

    task automatic check(input string tag, input logic [NP-1:0] act,
                         input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Model update at each clock edge from the inputs held since the last negedge.
    always @(posedge clk) begin
        int p, b, i, g, c;
        logic [4:0] v;
        if (!rst_n) begin
            m_d = '0; m_dir = '0; m_en = '0; m_s0 = '0; m_s1 = '0; m_s2 = '0;
            m_st = '0; m_db1 = '0; m_db2 = '0; m_rt = '0; m_c0 = '0;
            m_c1 = '0; m_im = '0; m_pend = 0; m_err = 1'b0;
        end else begin
            c = int'(wr_data[19:16]);
            m_err = wr_en && (wr_data[12] || c > 6);
            if (wr_en && c <= 6) begin
                p = int'(wr_data[7:0]); b = p / BW; i = p % BW;
                v = wr_data[24:20];
                case (c)
                    0: begin
                        m_d[p] = v[0];
                        for (int k = 0; k < BW; k++) if (!OUC[k]) m_d[b*BW+k] = 1'b0;
                    end
                    1: begin
                        m_dir[p] = v[0];
                        for (int k = 0; k < BW; k++)
                            m_dir[b*BW+k] = (m_dir[b*BW+k] | !INC[k]) & OUC[k];
                    end
                    2: begin
                        m_en[p] = v[0]; m_s0[p] = v[1]; m_s1[p] = v[2]; m_s2[p] = v[3];
                        if (v[4]) m_st[p] = 1'b0;
                    end
                    3: begin m_db1[p] = v[0]; m_db2[p] = v[1]; end
                    4: m_rt[p] = v[0];
                    5: begin
                        g = (i / 8) * 8;
                        m_c0[b*BW+g] = v[0]; m_c1[b*BW+g] = v[1];
                        for (int k = 0; k < BW; k++) if (!CSM[k]) begin
                            m_c0[b*BW+k] = 1'b0; m_c1[b*BW+k] = 1'b0;
                        end
                    end
                    default: m_im[p] = v[0] & INC[i];
                endcase
            end
            m_st = m_st | irq_raise;
            m_pend = $countones(m_st);
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 pin_data", pin_data, m_d);
            check("R4 pin_dir", pin_dir, m_dir);
            check("R5 irq_en", irq_en, m_en);
            check("R5 irq_sens", {irq_sens0 ^ irq_sens1, irq_sens2} == {m_s0 ^ m_s1, m_s2} ? '0 : '1, '0);
            check("R6 irq_stat", irq_stat, m_st);
            check("R6 irq_pending", NP'(irq_pending), NP'(m_pend));
            check("R7 debounce", dbnc_sel1 ^ (dbnc_sel2 << 1), m_db1 ^ (m_db2 << 1));
            check("R7 rst_tol", rst_tol, m_rt);
            check("R8 csrc0", csrc0, m_c0);
            check("R8 csrc1", csrc1, m_c1);
            check("R9 in_mask", in_mask, m_im);
            check("R10 cmd_err", NP'(cmd_err), NP'(m_err));
        end
    end

    function automatic logic [31:0] word(input int pin, input int cls,
                                         input logic [4:0] v, input logic cmd);
        return {7'b0, v, 4'(cls), 3'b0, cmd, 4'b0, 8'(pin)};
    endfunction

    task automatic wr(input int pin, input int cls, input logic [4:0] v,
                      input logic cmd);
        wr_en = 1'b1; wr_data = word(pin, cls, v, cmd);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs.
        check("R1 reset data", pin_data | pin_dir | irq_stat | csrc0, '0);
        check("R1 reset pending/err", NP'({irq_pending, cmd_err}), '0);
        // R2: pin 37 lands in bank 1, position 5, alone.
        wr(37, 0, 5'b00001, 1'b0);
        check("R2 single bit", pin_data, NP'(1) << 37);
        // R3: input-only pin 16 cannot hold data.
        wr(16, 0, 5'b00001, 1'b0);
        check("R3 input-only data", NP'(pin_data[16]), '0);
        // R4: direction write pin 3 -> bank0 word 0x0000FF08.
        wr(3, 1, 5'b00001, 1'b0);
        check("R4 dir force", NP'(pin_dir[31:0]), NP'(32'h0000_FF08));
        // R12: strobe low, live word ignored.
        wr_data = word(200, 0, 5'b00001, 1'b0);
        @(negedge clk);
        check("R12 no strobe", NP'({pin_data[200], cmd_err}), '0);
        wr_data = '0;
        // R11: reserved bit flags but write is applied.
        wr(1, 0, 5'b00001, 1'b1);
        check("R11 err and write", NP'({cmd_err, pin_data[1]}), NP'(2'b11));
        // R10: class 9 flags error.
        wr(2, 9, 5'b11111, 1'b0);
        check("R10 invalid class err", NP'({cmd_err, pin_data[2]}), NP'(2'b10));
        // R8: pin 45 (group 1 of bank 1) sets bit 40.
        wr(45, 5, 5'b00011, 1'b0);
        check("R8 group bit", csrc0 | csrc1, NP'(1) << 40);
        // R5/R6: raise then clear pin 70.
        irq_raise = NP'(1) << 70; @(negedge clk); irq_raise = '0;
        check("R6 raised count", NP'(irq_pending), NP'(1));
        wr(70, 2, 5'b10001, 1'b0);
        check("R5 w1c", NP'({irq_stat[70], irq_en[70]}), NP'(2'b01));
        // Pseudo-random mix checked by the model.
        for (int n = 0; n < 3000; n++) begin
            int c;
            c = int'($urandom % 9);
            if (c > 6) c = 7 + int'($urandom % 9);
            wr_en   = ($urandom % 2) == 0;
            wr_data = word(int'($urandom % NP), c, 5'($urandom),
                           ($urandom % 16) == 0);
            irq_raise = '0;
            if (($urandom % 4) == 0) irq_raise[$urandom % NP] = 1'b1;
            if (($urandom % 6) == 0) irq_raise[wr_data[7:0]] = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0; irq_raise = '0;
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule